// File: doc/BRIEF.md
# PWM Gate Drive Chopping Unit

This block sits between a three-phase PWM generator and the six gate-drive outputs, three for the high-side switches and three for the low-side switches. It can modulate every active PWM pulse with a high-frequency square carrier. This lets the gate signals pass through pulse transformers, which cannot carry a long DC level. A ten-bit control word sets the carrier divider and holds two separate enables: one for the high-side group and one for the low-side group.

One free-running counter produces the carrier, and all six channels share it, so chopped edges line up across phases and across groups. Each output has exactly one register stage, whether its group is chopped or passed straight through. A raw PWM signal that is low, including during the dead time the generator inserts, always gives a low output. The control word is meant to be written before the PWM starts running.

Top module: `pwm_chop_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the control word, the carrier counter and all six outputs are cleared after that edge. After reset, both groups therefore pass their inputs through unchopped.
- R2: A write (`cfg_we` high at a clock edge) loads `cfg_wdata` into the control word. Bits 7:0 are the divider D (0 to 255), bit 8 enables high-side chopping and bit 9 enables low-side chopping. The new value governs the outputs registered from the following edge onward.
- R3: The carrier period is 4×(D+1) clocks. The carrier is high while the counter value is below 2×(D+1) and low for the rest of the period. The counter is zero on the first cycle after reset.
- R4: When a group is enabled, each output of that group equals its raw input ANDed with the carrier, both sampled one clock earlier.
- R5: An output whose raw input was low on the previous clock is low, whatever the enables and carrier are.
- R6: The two enables act independently. A group whose enable is clear is not chopped while the other group is.
- R7: When a group's enable is clear, each output of that group equals its raw input one clock earlier. This is the same single-cycle latency as the chopped path.
- R8: All chopped channels use the same carrier. With every raw input high and both groups enabled, all six outputs are equal on every cycle.
- R9: If the divider is lowered while the counter already holds a value at or above the new period minus one, the counter returns to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 10 | Control word: divider [7:0], high enable [8], low enable [9] |
| pwm_hi_raw | input | 3 | Raw active-high PWM, high-side switches |
| pwm_lo_raw | input | 3 | Raw active-high PWM, low-side switches |
| gate_hi | output | 3 | Gated high-side drive signals |
| gate_lo | output | 3 | Gated low-side drive signals |

## Verification
The bench builds the block with its default parameters: an 8-bit divider and three phases. Because a full carrier period is at most 1024 clocks, runs at D=255 fit easily, and so do the shortest period of 4 clocks at D=0 and a mid-range value. Writes that lower the divider after the counter has passed the new period reach the wrap-back corner. Random enable pairs cover both groups chopped, neither chopped, and each group chopped on its own.

// File: rtl/pwm_chop_pkg.sv
// Shared definitions for the PWM gate chopping unit.
// Assumes: two switch groups, high side and low side, in that order.
package pwm_chop_pkg;
    typedef enum logic {
        GRP_HIGH = 1'b0,
        GRP_LOW  = 1'b1
    } chop_grp_e;

    localparam int CHOP_GROUPS = 2;
endpackage

// File: rtl/pwm_chop_cfg.sv
// Control word register: divider in the low bits, then one enable per group.
// Assumes: writes are rare and happen before PWM operation starts.
module pwm_chop_cfg #(
    parameter int DIV_W = 8,
    localparam int CFG_W = DIV_W + pwm_chop_pkg::CHOP_GROUPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [DIV_W-1:0] divider,
    output logic [pwm_chop_pkg::CHOP_GROUPS-1:0] grp_en,
    output logic [CFG_W-1:0] cfg_q
);
    // Hold the control word; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg_q <= '0;
        else if (we) cfg_q <= wdata;
    end

    // Split the word into its fields.
    always_comb begin
        divider = cfg_q[DIV_W-1:0];
        grp_en  = cfg_q[CFG_W-1:DIV_W];
    end
endmodule

// File: rtl/pwm_chop_carrier.sv
// Free-running carrier generator. The period is 4*(div+1) clocks, high for
// the first half. Assumes the counter is wide enough for 4*2^DIV_W values.
module pwm_chop_carrier #(
    parameter int DIV_W = 8,
    localparam int CNT_W = DIV_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divider,
    output logic [CNT_W-1:0] cnt,
    output logic             carrier
);
    logic [CNT_W-1:0] last_cnt;   // 4*(D+1)-1
    logic [CNT_W-1:0] high_last;  // 2*(D+1)-1

    // Derive the terminal count and the end of the high half.
    always_comb begin
        last_cnt  = {divider, 2'b11};
        high_last = {1'b0, divider, 1'b1};
        carrier   = (cnt <= high_last);
    end

    // Count up and wrap at or past the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (cnt >= last_cnt)  cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_chop_gate.sv
// One switch group: registers each raw PWM bit, ANDed with the carrier
// when chopping is enabled. Both paths have one register stage.
module pwm_chop_gate #(
    parameter int PHASES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chop_en,
    input  logic              carrier,
    input  logic [PHASES-1:0] raw,
    output logic [PHASES-1:0] gated
);
    logic mask;

    // Choose the carrier, or a constant one when chopping is off.
    always_comb mask = chop_en ? carrier : 1'b1;

    for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
        // Register one gated channel.
        always_ff @(posedge clk) begin
            if (!rst_n) gated[ph] <= 1'b0;
            else        gated[ph] <= raw[ph] & mask;
        end
    end
endmodule

// File: rtl/pwm_chop_top.sv
// PWM gate drive chopping unit top. Six raw PWM signals in, six gated out,
// one carrier shared by every channel. Assumes raw inputs are synchronous.
module pwm_chop_top #(
    parameter int DIV_W  = 8,
    parameter int PHASES = 3,
    localparam int CFG_W = DIV_W + pwm_chop_pkg::CHOP_GROUPS,
    localparam int CNT_W = DIV_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [PHASES-1:0] pwm_hi_raw,
    input  logic [PHASES-1:0] pwm_lo_raw,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo
);
    import pwm_chop_pkg::*;

    logic [DIV_W-1:0]       divider;
    logic [CHOP_GROUPS-1:0] grp_en;
    logic [CFG_W-1:0]       cfg_q;
    logic [CNT_W-1:0]       car_cnt;
    logic                   carrier;
    logic [PHASES-1:0]      raw_grp   [CHOP_GROUPS];
    logic [PHASES-1:0]      gated_grp [CHOP_GROUPS];

    pwm_chop_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .divider(divider), .grp_en(grp_en), .cfg_q(cfg_q)
    );

    pwm_chop_carrier #(.DIV_W(DIV_W)) u_carrier (
        .clk(clk), .rst_n(rst_n), .divider(divider),
        .cnt(car_cnt), .carrier(carrier)
    );

    // Route the port groups into indexed arrays.
    always_comb begin
        raw_grp[GRP_HIGH] = pwm_hi_raw;
        raw_grp[GRP_LOW]  = pwm_lo_raw;
        gate_hi           = gated_grp[GRP_HIGH];
        gate_lo           = gated_grp[GRP_LOW];
    end

    for (genvar g = 0; g < CHOP_GROUPS; g++) begin : g_group
        pwm_chop_gate #(.PHASES(PHASES)) u_gate (
            .clk(clk), .rst_n(rst_n), .chop_en(grp_en[g]), .carrier(carrier),
            .raw(raw_grp[g]), .gated(gated_grp[g])
        );
    end
endmodule

// File: rtl/pwm_chop_checker.sv
// Timing properties of the chopping unit, bound to the top module.
module pwm_chop_checker #(
    parameter int DIV_W  = 8,
    parameter int PHASES = 3,
    localparam int CFG_W = DIV_W + 2,
    localparam int CNT_W = DIV_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_W-1:0]  cfg_q,
    input logic [CNT_W-1:0]  cnt,
    input logic [PHASES-1:0] raw_hi,
    input logic [PHASES-1:0] raw_lo,
    input logic [PHASES-1:0] gate_hi,
    input logic [PHASES-1:0] gate_lo
);
    localparam logic [PHASES-1:0] ALL1 = '1;

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (gate_hi == '0 && gate_lo == '0 && cfg_q == '0 && cnt == '0));

    a_r5_inactive_off: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((gate_hi & ~$past(raw_hi)) == '0 && (gate_lo & ~$past(raw_lo)) == '0));

    a_r7_hi_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[DIV_W] |=> gate_hi == $past(raw_hi));

    a_r7_lo_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[DIV_W+1] |=> gate_lo == $past(raw_lo));

    a_r4_low_half_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[DIV_W] && cnt > {1'b0, cfg_q[DIV_W-1:0], 1'b1}) |=> gate_hi == '0);

    a_r8_groups_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[DIV_W] && cfg_q[DIV_W+1] && raw_hi == ALL1 && raw_lo == ALL1)
        |=> (gate_hi == gate_lo && (gate_hi == '0 || gate_hi == ALL1)));

    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= {cfg_q[DIV_W-1:0], 2'b11}) |=> cnt == '0);
endmodule

bind pwm_chop_top pwm_chop_checker #(.DIV_W(DIV_W), .PHASES(PHASES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .cnt(car_cnt),
    .raw_hi(pwm_hi_raw), .raw_lo(pwm_lo_raw),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/pwm_chop_top_bench.sv
module pwm_chop_top_bench;
    localparam int DIV_W = 8;
    localparam int PH    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [9:0]    cfg_wdata = '0;
    logic [PH-1:0] pwm_hi_raw = '0;
    logic [PH-1:0] pwm_lo_raw = '0;
    logic [PH-1:0] gate_hi, gate_lo;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pwm_chop_top #(.DIV_W(DIV_W), .PHASES(PH)) u_pwm_chop_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .pwm_hi_raw(pwm_hi_raw), .pwm_lo_raw(pwm_lo_raw),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // Reference model built from the requirements.
    logic [9:0]    m_cfg = '0;
    logic [9:0]    m_cnt = '0;
    logic [PH-1:0] m_hi = '0, m_lo = '0;

    function automatic logic car_of(logic [9:0] cnt, logic [7:0] d);
        return int'(cnt) < 2 * (int'(d) + 1);
    endfunction

    function automatic logic [PH-1:0] gate_of(logic [PH-1:0] raw, logic en, logic car);
        return en ? (raw & {PH{car}}) : raw;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg <= '0; m_cnt <= '0; m_hi <= '0; m_lo <= '0;
        end else begin
            if (cfg_we) m_cfg <= cfg_wdata;
            m_cnt <= (int'(m_cnt) >= 4 * (int'(m_cfg[7:0]) + 1) - 1) ? '0 : m_cnt + 1'b1;
            m_hi  <= gate_of(pwm_hi_raw, m_cfg[8], car_of(m_cnt, m_cfg[7:0]));
            m_lo  <= gate_of(pwm_lo_raw, m_cfg[9], car_of(m_cnt, m_cfg[7:0]));
        end
    end

    task automatic check(string tag, logic [PH-1:0] act, logic [PH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one clock and compare both groups with the model.
    task automatic tick(string tag);
        @(posedge clk);
        @(negedge clk);
        check({tag, " hi"}, gate_hi, m_hi);
        check({tag, " lo"}, gate_lo, m_lo);
    endtask

    task automatic write_cfg(logic [9:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick("R2 write");
        cfg_we = 1'b0;
    endtask

    task automatic rand_run(string tag, int n);
        for (int i = 0; i < n; i++) begin
            pwm_hi_raw = PH'($urandom);
            pwm_lo_raw = PH'($urandom);
            tick(tag);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int hcount;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        // R1: reset clears outputs even with active inputs.
        pwm_hi_raw = '1; pwm_lo_raw = '1;
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            check("R1 reset hi", gate_hi, '0);
            check("R1 reset lo", gate_lo, '0);
        end
        rst_n = 1'b1;
        tick("R1 after reset");
        // R7: both groups pass through after reset.
        rand_run("R7 passthrough", 200);
        // R6: only high side chopped at the shortest period.
        write_cfg({2'b01, 8'd0});
        rand_run("R6 hi only", 300);
        write_cfg({2'b10, 8'd5});
        rand_run("R6 lo only", 300);
        // R3 and R8: all inputs high, both chopped, D=2.
        write_cfg({2'b11, 8'd2});
        pwm_hi_raw = '1; pwm_lo_raw = '1;
        tick("R3 settle");
        for (int p = 0; p < 3; p++) begin
            hcount = 0;
            for (int c = 0; c < 12; c++) begin
                tick("R3 period");
                if (gate_hi[0]) hcount++;
                n_chk++;
                if (!(gate_hi == gate_lo && (gate_hi == '0 || gate_hi == '1))) begin
                    n_fail++;
                    $display("FAIL R8: actual hi %b lo %b expected all equal", gate_hi, gate_lo);
                end
            end
            n_chk++;
            if (hcount != 6) begin
                n_fail++;
                $display("FAIL R3: actual high count %0d expected 6", hcount);
            end
        end
        // R3 at the largest divider: 512 high clocks per 1024.
        write_cfg({2'b11, 8'd255});
        hcount = 0;
        for (int c = 0; c < 1024; c++) begin
            tick("R3 max");
            if (gate_lo[2]) hcount++;
        end
        n_chk++;
        if (hcount != 512) begin
            n_fail++;
            $display("FAIL R3: actual high count %0d expected 512", hcount);
        end
        // R5: inactive inputs stay off while chopping.
        pwm_hi_raw = '0; pwm_lo_raw = '0;
        for (int c = 0; c < 60; c++) begin
            tick("R5 inactive");
            check("R5 hi zero", gate_hi, '0);
            check("R5 lo zero", gate_lo, '0);
        end
        // R9: lower the divider after the counter passes the new period.
        write_cfg({2'b11, 8'd200});
        rand_run("R9 pre", 150);
        write_cfg({2'b11, 8'd3});
        rand_run("R9 wrap", 100);
        // R4: random dividers and enables, including the extremes.
        for (int k = 0; k < 12; k++) begin
            d = (k == 0) ? 8'd0 : (k == 1) ? 8'd255 : 8'($urandom_range(0, 20));
            write_cfg({2'($urandom), d});
            rand_run("R4 random", (k == 1) ? 1100 : 300);
        end
        finish_run();
    end
endmodule